// File: doc/BRIEF.md
# Cascadable Pulse Accumulator Pair

This block holds two byte-wide edge counters. Each counts rising edges on its own synchronized input pin. A mode bit in the control register joins them into one 16-bit counter that takes its edges from input pin 0. Pin 0 is the pin that input-capture channel 0 also uses. In the joined mode the lower byte carries into the upper byte on the clock that counts the edge. When the 16-bit value wraps to zero, a sticky overflow flag is set. The flag can raise an interrupt request.

Software reaches four byte registers through a simple register port. The port has a write strobe, an address, write data and read data that follows the address with no wait. The per-byte enables come in from a neighbouring capture configuration register. They matter only while the joined mode is off.

Top module: `pacc_pair`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0x00 and `irq` is low.
- R2: With the joined mode off, the lower byte (address 2) counts rising edges on `pin_ch0` while `lo_en` is 1. The upper byte (address 3) counts rising edges on `pin_ch1` while `hi_en` is 1. A byte whose enable is 0 holds its value.
- R3: With the joined mode off, the lower byte rolls from 0xFF to 0x00 without changing the upper byte and without setting the overflow flag.
- R4: When control bit 6 is 1, the two bytes form one 16-bit counter of `pin_ch0` rising edges, with the upper byte as the high half. Carry into the upper byte happens on the same clock as the counted edge. Edges on `pin_ch1` are not counted.
- R5: While control bit 6 is 1, `lo_en` and `hi_en` have no effect on counting.
- R6: A 16-bit wrap from 0xFFFF to 0x0000 sets the overflow flag, which reads as bit 1 of the flag register (address 1).
- R7: `irq` is high exactly when control bit 1 (interrupt enable) and the overflow flag are both 1.
- R8: Writing the flag register with bit 1 set clears the overflow flag. Writing it with bit 1 clear leaves the flag unchanged.
- R9: When a wrap and a clearing write to the flag register fall in the same cycle, the flag ends up set.
- R10: A write to a count byte loads that byte. If an edge would be counted into that byte in the same cycle, the write wins and the edge is dropped.
- R11: The register map is control at address 0, flag at address 1, lower byte at 2 and upper byte at 3. Control bits other than 6 and 1 read as 0, and flag bits other than 1 read as 0.
- R12: Each rising edge is counted once, however long the pin stays high. Falling edges are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_ch0 | input | 1 | Edge input 0, shared with capture channel 0; feeds the lower byte or the joined counter |
| pin_ch1 | input | 1 | Edge input 1; feeds the upper byte when the joined mode is off |
| lo_en | input | 1 | Enable for the lower byte while the joined mode is off |
| hi_en | input | 1 | Enable for the upper byte while the joined mode is off |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench uses the default parameters: 8-bit bytes and a two-stage synchronizer. With these, an edge reaches a count byte on the third clock after the pin changes, and the bench lines up its same-cycle races on that clock. Because the bytes are 8 bits wide, a preload through the register port sets up both the 8-bit rollover and the 16-bit wrap in a few edges. The bench can then drive a clearing flag write and a byte write into the exact cycle where the wrap or the count lands.

// File: rtl/pacc_pkg.sv
// Package: register addresses and field positions shared by the accumulator pair.
// Assumes an 8-bit or wider register data path so that bit 6 exists.
package pacc_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_LO   = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_HI   = 2'd3;
    localparam int BIT_JOIN = 6;
    localparam int BIT_IE   = 1;
    localparam int BIT_OVF  = 1;
endpackage

// File: rtl/pacc_edge_sync.sv
// Module: brings one asynchronous pin into the clock domain through a
// STAGES-deep flop chain and emits a one-cycle pulse per rising edge.
// Assumes STAGES >= 2.
module pacc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the pin through the synchronizer and remember the settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;

    // R12: a detected edge never yields two back-to-back pulses.
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pacc_byte_cnt.sv
// Module: one count byte with a load path that takes priority over the
// increment. Flags when the value is all ones so the caller can form a carry.
module pacc_byte_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         full
);
    // Load from the bus, else step by one on an accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end

    assign full = &cnt;

    // R10: a load lands regardless of a same-cycle increment.
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val));
    // R2: an accepted increment advances the byte by exactly one.
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld) |=> cnt == $past(cnt) + W'(1));
endmodule

// File: rtl/pacc_regs.sv
// Module: control and flag registers, read multiplexer and interrupt.
// The overflow flag is sticky, cleared by a one written to its bit, and a
// same-cycle set beats the clear. Assumes W >= 8.
module pacc_regs
    import pacc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              ovf_set,
    input  logic [W-1:0]      cnt_lo,
    input  logic [W-1:0]      cnt_hi,
    output logic [W-1:0]      rdata,
    output logic              join_mode,
    output logic              irq
);
    logic ie_q;
    logic flag_q;
    logic ctrl_wr;
    logic flag_clr;

    assign ctrl_wr  = wr && (addr == ADR_CTRL);
    assign flag_clr = wr && (addr == ADR_FLAG) && wdata[BIT_OVF];

    // Hold the join-mode and interrupt-enable bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            join_mode <= 1'b0;
            ie_q      <= 1'b0;
        end else if (ctrl_wr) begin
            join_mode <= wdata[BIT_JOIN];
            ie_q      <= wdata[BIT_IE];
        end
    end

    // Sticky overflow flag: set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ovf_set) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Select the addressed register; unused bits return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: begin
                rdata[BIT_JOIN] = join_mode;
                rdata[BIT_IE]   = ie_q;
            end
            ADR_FLAG: rdata[BIT_OVF] = flag_q;
            ADR_LO:   rdata = cnt_lo;
            default:  rdata = cnt_hi;
        endcase
    end

    assign irq = ie_q & flag_q;

    // R9: a set in the same cycle as a clear leaves the flag set.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> flag_q);
    // R8: a one written to the flag bit clears it when no set competes.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !ovf_set) |=> !flag_q);
    // R8: a zero written to the flag bit leaves it untouched.
    a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADR_FLAG && !wdata[BIT_OVF] && !ovf_set) |=> $stable(flag_q));
endmodule

// File: rtl/pacc_pair.sv
// Module: top of the accumulator pair. Two synchronized pins feed two count
// bytes, either separately under their own enables or, in join mode, as one
// 16-bit counter on pin 0 whose wrap sets the overflow flag.
// Assumes pins are asynchronous and the register port is single-cycle.
module pacc_pair
    import pacc_pkg::*;
#(
    parameter int W        = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_ch0,
    input  logic              pin_ch1,
    input  logic              lo_en,
    input  logic              hi_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              irq
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_v;
    logic [NPIN-1:0] rise_v;
    logic            join_mode;
    logic            wr_lo, wr_hi;
    logic            lo_step, lo_wrap, hi_step, ovf_set;
    logic [W-1:0]    cnt_lo, cnt_hi;
    logic            lo_full, hi_full;

    assign pin_v = {pin_ch1, pin_ch0};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        pacc_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_v[g]),
            .rise (rise_v[g])
        );
    end

    assign wr_lo   = reg_wr && (reg_addr == ADR_LO);
    assign wr_hi   = reg_wr && (reg_addr == ADR_HI);
    assign lo_step = rise_v[0] & (join_mode | lo_en);
    assign lo_wrap = lo_step & lo_full & ~wr_lo;
    assign hi_step = join_mode ? lo_wrap : (rise_v[1] & hi_en);
    assign ovf_set = join_mode & lo_wrap & hi_full & ~wr_hi;

    pacc_byte_cnt #(.W(W)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (wr_lo),
        .ld_val(reg_wdata),
        .inc   (lo_step),
        .cnt   (cnt_lo),
        .full  (lo_full)
    );

    pacc_byte_cnt #(.W(W)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (wr_hi),
        .ld_val(reg_wdata),
        .inc   (hi_step),
        .cnt   (cnt_hi),
        .full  (hi_full)
    );

    pacc_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ovf_set  (ovf_set),
        .cnt_lo   (cnt_lo),
        .cnt_hi   (cnt_hi),
        .rdata    (reg_rdata),
        .join_mode(join_mode),
        .irq      (irq)
    );

    // R6: a 16-bit wrap leaves both bytes at zero.
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> (cnt_lo == '0 && cnt_hi == '0));
    // R4: in join mode the upper byte moves only on a carry or a bus write.
    a_r4_hi_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
        (join_mode && !wr_hi && !lo_wrap) |=> $stable(cnt_hi));
    // R3: with join mode off the lower byte never raises the overflow flag.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !join_mode |-> !ovf_set);
endmodule

// File: tb/sim_pacc_pair.sv
module sim_pacc_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_ch0 = 1'b0, pin_ch1 = 1'b0, lo_en = 1'b0, hi_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    pacc_pair u0 (
        .clk(clk), .rst_n(rst_n), .pin_ch0(pin_ch0), .pin_ch1(pin_ch1),
        .lo_en(lo_en), .hi_en(hi_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, e);
    endtask

    task automatic pulse(input int which, input int high_cycles);
        @(negedge clk);
        if (which == 0) pin_ch0 = 1'b1; else pin_ch1 = 1'b1;
        repeat (high_cycles) @(negedge clk);
        if (which == 0) pin_ch0 = 1'b0; else pin_ch1 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", 2'd0, 8'h00);
        expect_reg("R1 flag", 2'd1, 8'h00);
        expect_reg("R1 lo", 2'd2, 8'h00);
        expect_reg("R1 hi", 2'd3, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_separate();
        lo_en = 1'b1; hi_en = 1'b0;
        for (int i = 0; i < 3; i++) pulse(0, 3);
        for (int i = 0; i < 2; i++) pulse(1, 3);
        expect_reg("R2 lo counts pin0", 2'd2, 8'h03);
        expect_reg("R2 hi disabled holds", 2'd3, 8'h00);
        hi_en = 1'b1;
        for (int i = 0; i < 2; i++) pulse(1, 3);
        expect_reg("R2 hi counts pin1", 2'd3, 8'h02);
        pulse(0, 12);
        expect_reg("R12 long high counts once", 2'd2, 8'h04);
    endtask

    task automatic t_byte_roll();
        wr(2'd2, 8'hFF);
        pulse(0, 3);
        expect_reg("R3 lo rolls", 2'd2, 8'h00);
        expect_reg("R3 hi untouched", 2'd3, 8'h02);
        expect_reg("R3 no flag", 2'd1, 8'h00);
    endtask

    task automatic t_join();
        lo_en = 1'b0; hi_en = 1'b0;
        wr(2'd0, 8'h40);
        wr(2'd2, 8'hFE);
        wr(2'd3, 8'h05);
        pulse(0, 3);
        pulse(0, 3);
        expect_reg("R4 lo after carry", 2'd2, 8'h00);
        expect_reg("R5 hi carried with enables off", 2'd3, 8'h06);
        hi_en = 1'b1; lo_en = 1'b1;
        pulse(1, 3);
        expect_reg("R4 pin1 ignored lo", 2'd2, 8'h00);
        expect_reg("R4 pin1 ignored hi", 2'd3, 8'h06);
        lo_en = 1'b0; hi_en = 1'b0;
    endtask

    task automatic t_wrap_irq();
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        pulse(0, 3);
        expect_reg("R6 lo zero", 2'd2, 8'h00);
        expect_reg("R6 hi zero", 2'd3, 8'h00);
        expect_reg("R6 flag set", 2'd1, 8'h02);
        check("R7 irq masked", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'h42);
        #1 check("R7 irq raised", {7'd0, irq}, 8'h01);
        wr(2'd1, 8'h00);
        expect_reg("R8 zero write keeps", 2'd1, 8'h02);
        wr(2'd1, 8'h02);
        expect_reg("R8 one write clears", 2'd1, 8'h00);
        #1 check("R7 irq dropped", {7'd0, irq}, 8'h00);
    endtask

    // Raise pin0, then place a write on the clock where the edge is counted.
    task automatic race(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        pin_ch0 = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        pin_ch0 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_races();
        wr(2'd2, 8'h10);
        wr(2'd3, 8'h20);
        race(2'd2, 8'h55);
        expect_reg("R10 write beats count", 2'd2, 8'h55);
        expect_reg("R10 hi unchanged", 2'd3, 8'h20);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        race(2'd1, 8'h02);
        expect_reg("R9 set beats clear", 2'd1, 8'h02);
        wr(2'd1, 8'h02);
    endtask

    task automatic t_reserved();
        wr(2'd0, 8'hFF);
        expect_reg("R11 ctrl unused bits", 2'd0, 8'h42);
        wr(2'd1, 8'hFF);
        expect_reg("R11 flag unused bits", 2'd1, 8'h00);
        wr(2'd0, 8'h00);
        expect_reg("R11 ctrl cleared", 2'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_separate();
        t_byte_roll();
        t_join();
        t_wrap_irq();
        t_races();
        t_reserved();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule